// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Interface

This block is the bus side of a 2 KB serial EEPROM. It receives the two-wire bus lines SCL and SDA, brings them into a fast system clock and finds their edges there. From those edges it detects start and stop conditions. It shifts bytes in and out most significant bit first and drives SDA only through an open-drain pull-low enable. Reads take data from a byte-wide memory port with combinational read. Every written data byte becomes a one-cycle request to a separate write controller, which holds the page buffer and programs the cells.

The address byte has a fixed device identifier in its top four bits, three block-select bits, and a read/write flag in bit 0. The block-select bits form the top three bits of the 11-bit memory address. The low eight bits come from an internal word pointer. The first byte of a write transaction loads this pointer, and the pointer advances after each byte transferred. While the write controller reports a write cycle in progress, the block refuses its address and leaves the bus alone.

A random read is a write-addressed transaction that loads the pointer, followed by a repeated start and a read-addressed byte. A current-address read uses the pointer as it stands. The system clock must run at least eight times the bus bit rate.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: Out of reset, the SDA pull-low enable is off and no write request is raised.
- R2: When the top four bits of the address byte are 1010 and no write cycle is busy, the block pulls SDA low during the 9th SCL pulse of that byte. Bit 0 = 0 selects write and bit 0 = 1 selects read.
- R3: An address byte whose identifier is not 1010 gets no acknowledge, and SDA stays released for every later byte until the next start condition.
- R4: While the write-busy input is high when the address byte completes, the block gives no acknowledge.
- R5: In a write transaction, the byte after the address byte is acknowledged and loaded into the 8-bit word pointer. Each later byte is acknowledged and raises one write request carrying address {block bits 3:1 of the address byte, pointer} and the byte. The pointer then increments.
- R6: The pointer increments modulo 256, from FF to 00, and the block bits stay unchanged.
- R7: In a read, the block sends the memory byte at {block, pointer} most significant bit first. SDA changes only while SCL is low.
- R8: During a read, a master acknowledge (SDA low on the 9th pulse) advances the pointer and starts the next byte. A master no-acknowledge leaves the pointer unchanged and SDA released until the next start.
- R9: A start condition in the middle of a byte, or a repeated start, abandons the current byte and begins a new address byte. It also releases SDA.
- R10: A stop condition returns the block to idle with SDA released. Bytes clocked after it are not acknowledged until a new start.
- R11: Each write request lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| wr_busy_i | input | 1 | Write controller is running a write cycle |
| mem_addr_o | output | ADDR_W (11) | Read address {block, pointer} |
| mem_rdata_i | input | 8 | Memory data at mem_addr_o, combinational |
| wr_req_o | output | 1 | One-cycle write request |
| wr_addr_o | output | ADDR_W (11) | Address of the requested write |
| wr_data_o | output | 8 | Data of the requested write |

## Verification
Writes start at pointer FE and run three bytes. The first request lands just below the top of the 256-byte block, and the third shows whether the pointer wraps inside that block. Sequential reads close with a master acknowledge and then a no-acknowledge, followed by a current-address read. This separates pointer advance on acknowledge from pointer hold on no-acknowledge. A wrong identifier, a busy write cycle, a start cut into the middle of a byte, and bytes clocked after a stop each probe one way the block must stay silent or resynchronise. Every read byte is checked for SDA changing while SCL is high.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEVADR,
        PH_DEVACK,
        PH_WADR,
        PH_WADRACK,
        PH_WDAT,
        PH_WDATACK,
        PH_RDAT,
        PH_RACK
    } phase_e;

endpackage

// File: rtl/i2c_eep_sync.sv
module i2c_eep_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[DEPTH-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign lvl[g]  = chain_q[STAGES-1];
        assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/i2c_eep_cond.sv
module i2c_eep_cond (
    input  logic scl_lvl,
    input  logic scl_rise,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    logic scl_held;

    always_comb begin
        scl_held = scl_lvl & ~scl_rise;
        start_o  = scl_held & sda_fall;
        stop_o   = scl_held & sda_rise;
    end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int          ADDR_W      = 11,
    parameter int          PTR_W       = 8,
    parameter logic [3:0]  DEV_ID      = 4'b1010,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wr_busy_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);
    import i2c_eep_pkg::*;

    localparam int BLK_W = ADDR_W - PTR_W;
    localparam int ID_W  = 7 - BLK_W;

    typedef struct packed {
        phase_e            ph;
        logic [2:0]        cnt;
        logic              full;
        logic [7:0]        sh;
        logic [PTR_W-1:0]  ptr;
        logic [BLK_W-1:0]  blk;
        logic              ack;
        logic              rnw;
        logic              oe;
        logic              wreq;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]        wdata;
    } regs_t;

    logic [1:0] line_lvl, line_rise, line_fall;
    logic       scl_lvl, scl_rise, scl_fall, sda_lvl;
    logic       start_evt, stop_evt;
    regs_t      d, q;

    i2c_eep_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_i, scl_i}),
        .lvl  (line_lvl),
        .rise (line_rise),
        .fall (line_fall)
    );

    assign scl_lvl  = line_lvl[0];
    assign scl_rise = line_rise[0];
    assign scl_fall = line_fall[0];
    assign sda_lvl  = line_lvl[1];

    i2c_eep_cond u_cond (
        .scl_lvl (scl_lvl),
        .scl_rise(scl_rise),
        .sda_rise(line_rise[1]),
        .sda_fall(line_fall[1]),
        .start_o (start_evt),
        .stop_o  (stop_evt)
    );

    always_comb begin
        d      = q;
        d.wreq = 1'b0;
        if (stop_evt) begin
            d.ph = PH_IDLE;
            d.oe = 1'b0;
        end else if (start_evt) begin
            d.ph   = PH_DEVADR;
            d.cnt  = '0;
            d.full = 1'b0;
            d.oe   = 1'b0;
        end else begin
            case (q.ph)
                PH_DEVADR, PH_WADR, PH_WDAT: begin
                    if (scl_rise && !q.full) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) d.full = 1'b1;
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.cnt  = '0;
                        if (q.ph == PH_DEVADR) begin
                            if (q.sh[7 -: ID_W] == DEV_ID[ID_W-1:0] && !wr_busy_i) begin
                                d.blk = q.sh[BLK_W:1];
                                d.rnw = q.sh[0];
                                d.ph  = PH_DEVACK;
                                d.oe  = 1'b1;
                            end else begin
                                d.ph = PH_IDLE;
                            end
                        end else if (q.ph == PH_WADR) begin
                            d.ptr = q.sh[PTR_W-1:0];
                            d.ph  = PH_WADRACK;
                            d.oe  = 1'b1;
                        end else begin
                            d.wreq  = 1'b1;
                            d.waddr = {q.blk, q.ptr};
                            d.wdata = q.sh;
                            d.ptr   = q.ptr + 1'b1;
                            d.ph    = PH_WDATACK;
                            d.oe    = 1'b1;
                        end
                    end
                end
                PH_DEVACK: begin
                    if (scl_fall) begin
                        if (q.rnw) begin
                            d.ph  = PH_RDAT;
                            d.cnt = '0;
                            d.sh  = mem_rdata_i;
                            d.oe  = ~mem_rdata_i[7];
                        end else begin
                            d.ph = PH_WADR;
                            d.oe = 1'b0;
                        end
                    end
                end
                PH_WADRACK, PH_WDATACK: begin
                    if (scl_fall) begin
                        d.ph = PH_WDAT;
                        d.oe = 1'b0;
                    end
                end
                PH_RDAT: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.ph  = PH_RACK;
                            d.oe  = 1'b0;
                            d.ack = 1'b0;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.cnt = q.cnt + 3'd1;
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        d.ack = ~sda_lvl;
                        if (!sda_lvl) d.ptr = q.ptr + 1'b1;
                    end else if (scl_fall) begin
                        if (q.ack) begin
                            d.ph  = PH_RDAT;
                            d.cnt = '0;
                            d.sh  = mem_rdata_i;
                            d.oe  = ~mem_rdata_i[7];
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign mem_addr_o = {q.blk, q.ptr};
    assign wr_req_o   = q.wreq;
    assign wr_addr_o  = q.waddr;
    assign wr_data_o  = q.wdata;
endmodule

// File: rtl/i2c_eep_checker.sv
module i2c_eep_checker #(
    parameter int ADDR_W = 11,
    parameter int PTR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              sda_oe_o,
    input logic              wr_busy_i,
    input logic              wr_req_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              devack_ph
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe_o && !wr_req_o));

    assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devack_ph) |-> !$past(wr_busy_i));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (mem_addr_o[PTR_W-1:0] == PTR_W'(wr_addr_o[PTR_W-1:0] + 1'b1)
                      && mem_addr_o[ADDR_W-1:PTR_W] == wr_addr_o[ADDR_W-1:PTR_W]));

    assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);

    assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe_o);

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe_o);

    assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |=> !wr_req_o);
endmodule

bind i2c_eeprom_slave i2c_eep_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_oe_o  (sda_oe_o),
    .wr_busy_i (wr_busy_i),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .mem_addr_o(mem_addr_o),
    .devack_ph (q.ph == i2c_eep_pkg::PH_DEVACK)
);

// File: tb/sim_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_slave;
    localparam int Q = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        wr_busy = 1'b0;
    logic        sda_oe;
    logic [10:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        wr_req;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;
    wire         sda_bus = sda_m & ~sda_oe;

    int ntest = 0;
    int nfail = 0;
    int nwr   = 0;
    logic [18:0] exp_wr[$];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [10:0] a);
        return 8'(a * 29 + (a >> 8) * 3 + 7);
    endfunction

    assign mem_rdata = pat(mem_addr);

    i2c_eeprom_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .wr_busy_i(wr_busy), .mem_addr_o(mem_addr),
        .mem_rdata_i(mem_rdata), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for write requests (R5, R6, R11)
    logic wr_prev = 1'b0;
    always @(negedge clk) begin
        if (wr_req) begin
            nwr++;
            if (exp_wr.size() == 0) chk("R5 unexpected write request", {13'd0, wr_addr, wr_data}, 32'hFFFF_FFFF);
            else chk("R5/R6 write request addr,data", {13'd0, wr_addr, wr_data}, {13'd0, exp_wr.pop_front()});
        end
        if (wr_req && wr_prev) chk("R11 write request width", 32'd2, 32'd1);
        wr_prev <= wr_req;
    end

    task automatic wq(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic xfer_bit(input logic b, output logic seen, output logic stable);
        logic a;
        sda_m = b; wq();
        scl_m = 1'b1; wq(4);
        a = sda_bus;
        wq(2 * Q - 4);
        seen = sda_bus;
        stable = (a === seen);
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic s, st;
        for (int i = 7; i >= 0; i--) xfer_bit(v[i], s, st);
        xfer_bit(1'b1, s, st);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v, output logic stable);
        logic s, st;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, s, st);
            v[i] = s;
            stable &= st;
        end
        xfer_bit(~mack, s, st);
    endtask

    task automatic set_ptr(input logic [2:0] blk, input logic [7:0] p);
        logic ak;
        i2c_start();
        send_byte({4'b1010, blk, 1'b0}, ak); chk("R2 write address ack", ak, 1'b1);
        send_byte(p, ak);                    chk("R5 word address ack", ak, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        logic ak, st;
        logic [7:0] v;
        wq(5);
        chk("R1 reset sda_oe", sda_oe, 1'b0);
        chk("R1 reset wr_req", wr_req, 1'b0);
        rst_n = 1'b1;
        wq(10);

        // R5/R6: page write across pointer wrap in block 2
        set_ptr(3'd2, 8'hFE);
        exp_wr.push_back({11'h2FE, 8'h11});
        send_byte(8'h11, ak); chk("R5 data ack 1", ak, 1'b1);
        exp_wr.push_back({11'h2FF, 8'h22});
        send_byte(8'h22, ak); chk("R5 data ack 2", ak, 1'b1);
        exp_wr.push_back({11'h200, 8'h33});
        send_byte(8'h33, ak); chk("R6 data ack after wrap", ak, 1'b1);
        i2c_stop();
        wq(10);

        // R3: wrong identifier
        i2c_start();
        send_byte(8'h92, ak); chk("R3 wrong id no ack", ak, 1'b0);
        send_byte(8'h00, ak); chk("R3 later byte stays released", ak, 1'b0);
        i2c_stop();

        // R4: busy write cycle
        wr_busy = 1'b1;
        i2c_start();
        send_byte(8'hA0, ak); chk("R4 busy no ack", ak, 1'b0);
        i2c_stop();
        wr_busy = 1'b0;

        // R7/R8/R9: random read in block 5 via repeated start
        set_ptr(3'd5, 8'h10);
        i2c_start();
        send_byte(8'hAB, ak); chk("R2 read address ack", ak, 1'b1);
        recv_byte(1'b1, v, st);
        chk("R7 read byte 0", v, pat(11'h510)); chk("R7 stable while SCL high", st, 1'b1);
        recv_byte(1'b0, v, st);
        chk("R8 read byte after ack", v, pat(11'h511)); chk("R7 stable byte 1", st, 1'b1);
        recv_byte(1'b0, v, st);
        chk("R8 released after nack", v, 8'hFF);
        i2c_stop();

        // R8: current-address read, pointer held by nack
        i2c_start();
        send_byte(8'hAB, ak); chk("R2 current read ack", ak, 1'b1);
        recv_byte(1'b0, v, st);
        chk("R8 pointer unchanged by nack", v, pat(11'h511));
        i2c_stop();

        // R9: start cut into the middle of a byte
        i2c_start();
        begin
            logic s, t;
            xfer_bit(1'b1, s, t); xfer_bit(1'b0, s, t);
            xfer_bit(1'b1, s, t); xfer_bit(1'b0, s, t);
        end
        i2c_start();
        send_byte(8'hA7, ak); chk("R9 address after mid-byte start ack", ak, 1'b1);
        recv_byte(1'b0, v, st);
        chk("R9 read block 3", v, pat(11'h311));
        i2c_stop();

        // R10: stop returns to idle
        i2c_start();
        send_byte(8'hA0, ak); chk("R10 ack before stop", ak, 1'b1);
        i2c_stop();
        send_byte(8'hA0, ak); chk("R10 no ack after stop", ak, 1'b0);
        send_byte(8'h55, ak); chk("R10 still idle", ak, 1'b0);
        chk("R10 sda released in idle", sda_oe, 1'b0);

        wq(10);
        chk("R5 write requests seen", nwr, 3);
        chk("R5 scoreboard drained", exp_wr.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule